// File: doc/BRIEF.md
# Serial PCM Word Transmitter for Audio DACs

This block takes signed PCM samples from a parallel valid/ready handshake and sends them to one or two serial audio DACs. It uses three wires: a bit clock, a data line per channel, and an active-low latch strobe. Each sample is two's complement and goes out most significant bit first. The receiver takes a bit on every rising bit-clock edge. The data line therefore only moves while the clock is low. When the last bit has been clocked, the block waits one half-bit and then gives a single low strobe of a set width. That strobe tells the DAC to move the received word into its conversion register.

All timing comes from the system clock. Each bit-clock phase lasts `HALF_CYC` system cycles. The strobe lasts `STROBE_CYC` cycles. At elaboration, the block rejects parameter sets that break the receiver's limits:
- each clock phase must be at least 30 ns;
- the bit period must be at least 80 ns for 16-bit words, or 74.1 ns for 18-bit words;
- the strobe must be at least 40 ns.

Data always changes half a bit away from a rising edge, so the setup and hold margins are each one phase. For stereo use (`CHANNELS` = 2), both DACs share the clock and the strobe, and each has its own data line. A new sample is accepted only after the previous word and its strobe are finished.

Top module: `pcm_serial_tx`

## Requirements
- R1: Channel c transmits the word `s_data[c*WORD_W +: WORD_W]` captured at the handshake, bit WORD_W-1 first and bit 0 last, unchanged in two's complement form.
- R2: Each accepted sample produces exactly WORD_W rising edges of `bclk` before its strobe; the receiver samples `sdata` on those rising edges.
- R3: `sdata` changes only while `bclk` is low: once at acceptance and otherwise in the cycle `bclk` falls. It is stable for at least HALF_CYC cycles before each rising edge and stays stable while `bclk` is high.
- R4: While a word is being sent, each high phase and each low phase of `bclk` between bits lasts exactly HALF_CYC system cycles.
- R5: `latch_n` falls exactly HALF_CYC cycles after the last falling `bclk` edge of a word, only after all WORD_W bits, and stays low for exactly STROBE_CYC cycles.
- R6: With CHANNELS = 2, both data lines are clocked by the same `bclk` and `latch_n` and each carries its own channel's word.
- R7: `s_ready` is high only when idle. It is low whenever `bclk` is high or `latch_n` is low, and it is high again in the same cycle that `latch_n` returns high.
- R8: Changes of `s_data` while `s_valid` is low or the block is busy do not affect the word being transmitted.
- R9: During and after reset, `latch_n` is 1, `bclk` is 0, `sdata` is 0 and `s_ready` is 1. No strobe occurs without an accepted sample, and `sdata` returns to 0 after each word.
- R10: With `s_valid` held high, consecutive samples are accepted exactly (2*WORD_W+1)*HALF_CYC + STROBE_CYC + 1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Transmitter idle, sample taken on valid and ready |
| s_data | input | CHANNELS*WORD_W | Samples, channel 0 in the low word |
| bclk | output | 1 | Serial bit clock to the DACs |
| sdata | output | CHANNELS | Serial data lines, one per channel |
| latch_n | output | 1 | Active-low word transfer strobe |

## Verification
The hardest condition to reach from the ports is a fully back-to-back stream. In that stream the strobe of one word ends and the next word's first data bit appears within one system cycle. That is exactly where an off-by-one in the ready timing or the phase counters would appear. The bench keeps `s_valid` high across a burst of words. It checks the acceptance spacing, and it checks that no bit-clock edge or data change falls inside the strobe. Separately, it scrambles `s_data` right after every handshake, so that only a correctly captured word can match the scoreboard.

// File: rtl/pcm_tx_pkg.sv
// Package: shared types and timing helpers for the serial PCM transmitter.
// Assumes: timing values are given in picoseconds.
package pcm_tx_pkg;

    // Sequencer phases of one word transfer
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOW    = 3'd1,
        ST_HIGH   = 3'd2,
        ST_GAP    = 3'd3,
        ST_STROBE = 3'd4
    } tx_state_t;

    // Minimum receiver clock phase, data margin and strobe width
    localparam longint MIN_PHASE_PS  = 30000;
    localparam longint MIN_MARGIN_PS = 15000;
    localparam longint MIN_STROBE_PS = 40000;

    // Shortest bit period the receiver accepts for a given word length
    function automatic longint min_bit_ps(input int word_w);
        return (word_w >= 18) ? 64'd74100 : 64'd80000;
    endfunction

endpackage

// File: rtl/pcm_tx_timer.sv
// Module: down-counting phase timer.
// Loading value N-1 makes done rise after N cycles in the new phase.
// Assumes: load wins over counting; the counter rests at zero.
module pcm_tx_timer #(
    parameter int MAX_CYC = 16,
    localparam int CW     = $clog2(MAX_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    // Count down toward zero, or restart on load
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Phase expires when the counter has reached zero
    always_comb done = (cnt_q == '0);

    // Without a load, a running count only moves downward
    p_timer_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pcm_tx_shifter.sv
// Module: per-channel parallel-load shift register, MSB first.
// Assumes: load and shift are never asserted together; zeros fill from the bottom.
module pcm_tx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] din,
    output logic              sout
);

    logic [WORD_W-1:0] sreg_q;

    // Capture the sample, or advance one bit toward the MSB
    always_ff @(posedge clk) begin
        if (!rst_n)
            sreg_q <= '0;
        else if (load)
            sreg_q <= din;
        else if (shift)
            sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
    end

    // Line always shows the current MSB
    always_comb sout = sreg_q[WORD_W-1];

    // With no control strobe, the register holds its contents
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(sreg_q));

    // Loading and shifting are exclusive
    p_ctl_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));

endmodule

// File: rtl/pcm_tx_ctrl.sv
// Module: word sequencer. It produces the bit-clock phases, the shift strobes,
// the post-word gap and the latch strobe, and it owns the input handshake.
// Assumes: HALF_CYC >= 1 and STROBE_CYC >= 1; bclk and latch_n are registered.
module pcm_tx_ctrl
    import pcm_tx_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int HALF_CYC   = 10,
    parameter int STROBE_CYC = 11,
    localparam int TMAX      = (HALF_CYC > STROBE_CYC) ? HALF_CYC : STROBE_CYC,
    localparam int CW        = $clog2(TMAX + 1),
    localparam int BW        = $clog2(WORD_W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_valid,
    output logic          s_ready,
    input  logic          t_done,
    output logic          t_load,
    output logic [CW-1:0] t_val,
    output logic          sh_load,
    output logic          sh_shift,
    output logic          bclk,
    output logic          latch_n
);

    localparam logic [CW-1:0] HALF_LD   = CW'(HALF_CYC - 1);
    localparam logic [CW-1:0] STROBE_LD = CW'(STROBE_CYC - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(WORD_W - 1);

    tx_state_t     state_q, state_d;
    logic [BW-1:0] bits_q;
    logic          bclk_q, latch_n_q;
    logic          accept;

    // Handshake completes only when idle
    always_comb begin
        s_ready = (state_q == ST_IDLE);
        accept  = s_valid && s_ready;
    end

    // Next phase, timer reload and shift-register controls
    always_comb begin
        state_d  = state_q;
        t_load   = 1'b0;
        t_val    = HALF_LD;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                state_d = ST_LOW;
                t_load  = 1'b1;
                sh_load = 1'b1;
            end
            ST_LOW: if (t_done) begin
                state_d = ST_HIGH;
                t_load  = 1'b1;
            end
            ST_HIGH: if (t_done) begin
                state_d  = (bits_q == LAST_BIT) ? ST_GAP : ST_LOW;
                t_load   = 1'b1;
                sh_shift = 1'b1;
            end
            ST_GAP: if (t_done) begin
                state_d = ST_STROBE;
                t_load  = 1'b1;
                t_val   = STROBE_LD;
            end
            ST_STROBE: if (t_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register and bits-sent counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bits_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept)
                bits_q <= '0;
            else if (sh_shift)
                bits_q <= bits_q + 1'b1;
        end
    end

    // Registered link outputs, glitch-free by construction of the phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q    <= 1'b0;
            latch_n_q <= 1'b1;
        end else begin
            bclk_q    <= (state_d == ST_HIGH);
            latch_n_q <= (state_d != ST_STROBE);
        end
    end

    always_comb begin
        bclk    = bclk_q;
        latch_n = latch_n_q;
    end

    // The strobe starts only once every bit of the word has been shifted
    p_strobe_after_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch_n_q) |-> (bits_q == BW'(WORD_W)));

    // Idle means quiet link lines
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (latch_n_q && !bclk_q));

    // Clock and strobe never overlap
    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bclk_q && !latch_n_q));

    // A strobe longer than one cycle does not end early
    if (STROBE_CYC > 1) begin : g_strobe_min
        p_strobe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(latch_n_q) |=> !latch_n_q);
    end

endmodule

// File: rtl/pcm_serial_tx.sv
// Module: serial PCM transmitter top. It has one shift register per channel, a
// shared sequencer and timer, and elaboration checks of the receiver timing minima.
// Assumes: SYS_PERIOD_PS gives the real clock period; channel c is in s_data[c*WORD_W +: WORD_W].
module pcm_serial_tx
    import pcm_tx_pkg::*;
#(
    parameter int WORD_W        = 16,
    parameter int CHANNELS      = 2,
    parameter int SYS_PERIOD_PS = 4000,
    parameter int HALF_CYC      = 10,
    parameter int STROBE_CYC    = 11,
    localparam int TMAX         = (HALF_CYC > STROBE_CYC) ? HALF_CYC : STROBE_CYC,
    localparam int CW           = $clog2(TMAX + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       s_valid,
    output logic                       s_ready,
    input  logic [CHANNELS*WORD_W-1:0] s_data,
    output logic                       bclk,
    output logic [CHANNELS-1:0]        sdata,
    output logic                       latch_n
);

    localparam longint HALF_PS   = longint'(HALF_CYC) * SYS_PERIOD_PS;
    localparam longint STROBE_PS = longint'(STROBE_CYC) * SYS_PERIOD_PS;

    // Reject parameter sets that violate the receiver's timing limits
    if (HALF_PS < MIN_PHASE_PS || HALF_PS < MIN_MARGIN_PS) begin : g_bad_phase
        $error("pcm_serial_tx: bit-clock phase shorter than receiver minimum");
    end
    if (2 * HALF_PS < min_bit_ps(WORD_W)) begin : g_bad_period
        $error("pcm_serial_tx: bit period shorter than receiver minimum");
    end
    if (STROBE_PS < MIN_STROBE_PS) begin : g_bad_strobe
        $error("pcm_serial_tx: latch strobe shorter than receiver minimum");
    end
    if (CHANNELS < 1 || CHANNELS > 2 || WORD_W < 2) begin : g_bad_shape
        $error("pcm_serial_tx: unsupported channel count or word length");
    end

    logic          t_load, t_done, sh_load, sh_shift;
    logic [CW-1:0] t_val;

    pcm_tx_ctrl #(
        .WORD_W     (WORD_W),
        .HALF_CYC   (HALF_CYC),
        .STROBE_CYC (STROBE_CYC)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_valid  (s_valid),
        .s_ready  (s_ready),
        .t_done   (t_done),
        .t_load   (t_load),
        .t_val    (t_val),
        .sh_load  (sh_load),
        .sh_shift (sh_shift),
        .bclk     (bclk),
        .latch_n  (latch_n)
    );

    pcm_tx_timer #(
        .MAX_CYC (TMAX)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    // One shift register per data line, all driven by the shared controls
    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        pcm_tx_shifter #(
            .WORD_W (WORD_W)
        ) shifter_i (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (sh_load),
            .shift (sh_shift),
            .din   (s_data[c*WORD_W +: WORD_W]),
            .sout  (sdata[c])
        );
    end

    // Data is frozen across a rising edge and throughout the high phase
    p_data_quiet_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bclk |-> $stable(sdata));

    // Busy link means no new sample is offered the handshake
    p_ready_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk || !latch_n) |-> !s_ready);

    // During the strobe every data line is back at zero
    p_zero_in_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_n |-> (sdata == '0));

    // A high phase longer than one cycle is never cut short
    if (HALF_CYC > 1) begin : g_phase_min
        p_high_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(bclk) |=> bclk);
    end

endmodule

// File: tb/pcm_serial_tx_tb_top.sv
// Scoreboard bench: the driver queues each offered sample, and the monitor rebuilds
// words from the serial lines and compares them at each latch strobe.
module pcm_serial_tx_tb_top;

    localparam int W      = 16;
    localparam int CH     = 2;
    localparam int HALF   = 10;
    localparam int STROBE = 11;
    localparam int PERIOD = (2 * W + 1) * HALF + STROBE + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              s_valid = 1'b0;
    logic              s_ready;
    logic [CH*W-1:0]   s_data = '0;
    logic              bclk;
    logic [CH-1:0]     sdata;
    logic              latch_n;

    int  checks = 0;
    int  failures = 0;
    longint cyc = 0;
    bit  finished = 1'b0;

    logic [CH*W-1:0] exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pcm_serial_tx #(
        .WORD_W        (W),
        .CHANNELS      (CH),
        .SYS_PERIOD_PS (4000),
        .HALF_CYC      (HALF),
        .STROBE_CYC    (STROBE)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_valid (s_valid),
        .s_ready (s_ready),
        .s_data  (s_data),
        .bclk    (bclk),
        .sdata   (sdata),
        .latch_n (latch_n)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor state
    logic          prev_bclk = 1'b0;
    logic          prev_latch = 1'b1;
    logic [CH-1:0] prev_sd = '0;
    int lvl_cnt = 0, since_chg = 0, fall_age = 0, lat_cnt = 0, bitcnt = 0;
    int strobes = 0, viol_high = 0, viol_ready = 0;
    logic [W-1:0] acc [CH];

    // Decode the link away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            fall_age++;
            if (sdata != prev_sd) begin
                since_chg = 0;
                if (bclk) viol_high++;
            end else since_chg++;
            if ((bclk || !latch_n) && s_ready) viol_ready++;

            if (bclk != prev_bclk) begin
                if (bclk) begin
                    if (bitcnt > 0) check(lvl_cnt == HALF, "R4 low phase", lvl_cnt, HALF);
                    check(since_chg >= HALF, "R3 setup before rise", since_chg, HALF);
                    for (int c = 0; c < CH; c++) acc[c] = {acc[c][W-2:0], sdata[c]};
                    bitcnt++;
                end else begin
                    check(lvl_cnt == HALF, "R4 high phase", lvl_cnt, HALF);
                    fall_age = 0;
                end
                lvl_cnt = 1;
            end else lvl_cnt++;

            if (latch_n != prev_latch) begin
                if (!latch_n) begin
                    logic [CH*W-1:0] got, exp;
                    strobes++;
                    check(bitcnt == W, "R2 bits per word", bitcnt, W);
                    check(fall_age == HALF, "R5 gap to strobe", fall_age, HALF);
                    for (int c = 0; c < CH; c++) got[c*W +: W] = acc[c];
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9 strobe without sample", got, 0);
                    end else begin
                        exp = exp_q.pop_front();
                        check(got == exp, "R1 R6 word content", got, exp);
                    end
                    bitcnt = 0;
                    lat_cnt = 1;
                end else begin
                    check(lat_cnt == STROBE, "R5 strobe width", lat_cnt, STROBE);
                    check(s_ready == 1'b1, "R7 ready at strobe end", s_ready, 1);
                end
            end else if (!latch_n) lat_cnt++;

            prev_bclk  = bclk;
            prev_latch = latch_n;
            prev_sd    = sdata;
        end
    end

    longint last_acc = 0;

    // Driver: offer a sample, wait for the handshake, then scramble the input (R8)
    task automatic send(input logic [CH*W-1:0] w, input bit b2b);
        exp_q.push_back(w);
        @(negedge clk);
        s_valid = 1'b1;
        s_data  = w;
        while (!s_ready) @(negedge clk);
        @(posedge clk);
        #1;
        if (b2b) check(cyc - last_acc == PERIOD, "R10 accept spacing", cyc - last_acc, PERIOD);
        last_acc = cyc;
        s_data  = ~w ^ 32'h3C96_5AA5;
        s_valid = b2b;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [CH*W-1:0] lf;
        repeat (4) @(negedge clk);
        // R9: reset state
        check(latch_n == 1'b1, "R9 reset latch_n", latch_n, 1);
        check(bclk == 1'b0, "R9 reset bclk", bclk, 0);
        check(sdata == '0, "R9 reset sdata", sdata, 0);
        check(s_ready == 1'b1, "R9 reset ready", s_ready, 1);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        check(strobes == 0 && latch_n && !bclk, "R9 no strobe while idle", strobes, 0);

        // R1 R6 R8: isolated words with distinct channel patterns
        send({16'h7FFF, 16'h8000}, 1'b0); s_valid = 1'b0; repeat (PERIOD + 30) @(negedge clk);
        send({16'hFFFF, 16'h0001}, 1'b0); s_valid = 1'b0; repeat (PERIOD + 30) @(negedge clk);
        send({16'h5A3C, 16'hA5C3}, 1'b0); s_valid = 1'b0; repeat (PERIOD + 30) @(negedge clk);
        send({16'h8001, 16'h0000}, 1'b0); s_valid = 1'b0; repeat (PERIOD + 30) @(negedge clk);
        check(sdata == '0, "R9 data zero after word", sdata, 0);

        // R10: back-to-back burst with valid held high
        lf = 32'hACE1_1357;
        send(lf, 1'b0);
        for (int i = 0; i < 6; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            send(lf, 1'b1);
        end
        s_valid = 1'b0;
        repeat (PERIOD + 200) @(negedge clk);

        check(exp_q.size() == 0, "R2 all words strobed", exp_q.size(), 0);
        check(strobes == 11, "R9 strobe count", strobes, 11);
        check(viol_high == 0, "R3 data moved while bclk high", viol_high, 0);
        check(viol_ready == 0, "R7 ready while busy", viol_ready, 0);
        check(latch_n && !bclk && sdata == '0 && s_ready, "R9 idle after traffic", {latch_n, bclk, sdata, s_ready}, 5'b10001);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule